// File: doc/BRIEF.md
# Sub-addressed I2C control slave

This block is an I2C slave that holds a bank of byte-wide control settings and returns one status byte when read. SCL and SDA are sampled by the system clock through a short synchronizer. The slave acknowledges by pulling SDA low through an open-drain output enable. It never stretches the clock.

In a write transaction the master sends the write address and then any number of byte pairs. The first byte of each pair is a sub-address and the second is the value for that register. There is no auto-increment. A lone byte in the sub-address position is only taken as a pointer, so a value is never written without its own sub-address in front of it. Start and stop conditions re-arm the pairing. In a read transaction the slave captures the status input at its address acknowledge and shifts that byte out MSB first. It repeats the byte for as long as the master acknowledges.

Top module: `i2c_ctl_slave`

## Requirements
- R1: After reset every register reads 0x00, SDA is released (`sda_oe_o` = 0) and `wr_stb_o` is low.
- R2: The slave acknowledges the 7-bit address 0x42, which is 0x84 for a write and 0x85 for a read, and it acknowledges every byte of a write transaction. For any other address it does not acknowledge, and it ignores the following bytes until the next start.
- R3: After the write address, bytes alternate between sub-address and data. A data byte loads register `sub` with one one-cycle `wr_stb_o` pulse and `wr_sub_o` = `sub`. Register `k` occupies `regs_o[8k+7:8k]`. Registers change only together with that pulse.
- R4: A data byte whose sub-address is NUM_REGS (default 8) or more writes nothing and gives no strobe. In the sequence 03, 08, 09, 0A only 08 lands in register 3.
- R5: A start or a stop returns the alternation to the sub-address position. This also applies to a repeated start that follows a dangling sub-address.
- R6: One write transaction may contain pairs for any mix of sub-addresses, and each pair takes effect.
- R7: On a read, `status_i` is captured at the address acknowledge and is sent MSB first. A change of `status_i` during the byte has no effect. After a master ACK the same captured byte is sent again, and after a NACK the slave releases SDA and goes idle.
- R8: `sda_oe_o` changes only while the synchronized SCL is low, and it is low whenever the slave is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used to oversample the bus |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | I2C clock line |
| sda_i | input | 1 | I2C data line as seen on the bus |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| status_i | input | 8 | Status byte returned on read |
| regs_o | output | NUM_REGS*8 | Register bank, register k at bits 8k+7:8k |
| wr_stb_o | output | 1 | One-cycle pulse on each register write |
| wr_sub_o | output | 8 | Sub-address of the register just written |

## Verification
The assertions assume that each SCL high and low phase lasts longer than the synchronizer depth plus one clock. They also assume that SDA moves while SCL is high only to form a start or a stop, and that the master never issues a stop while the slave is pulling SDA low. The stimulus holds every SCL phase for eight or more system clocks and changes SDA one clock after SCL falls. It forms start and stop only while SDA is released, which keeps both the acknowledge window and the output-enable stability check valid.

// File: rtl/i2c_ctl_pkg.sv
package i2c_ctl_pkg;
  localparam int BYTE_W = 8;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_AACK, ST_WDATA, ST_WACK, ST_RDATA, ST_RACK
  } bit_st_e;
endpackage

// File: rtl/i2c_ctl_sync.sv
module i2c_ctl_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s_o,
  output logic sda_s_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_q, sda_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) begin
          scl_ff[g] <= 1'b1;
          sda_ff[g] <= 1'b1;
        end else begin
          scl_ff[g] <= scl_i;
          sda_ff[g] <= sda_i;
        end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) begin
          scl_ff[g] <= 1'b1;
          sda_ff[g] <= 1'b1;
        end else begin
          scl_ff[g] <= scl_ff[g-1];
          sda_ff[g] <= sda_ff[g-1];
        end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_ff[STAGES-1];
      sda_q <= sda_ff[STAGES-1];
    end

  assign scl_s_o    = scl_ff[STAGES-1];
  assign sda_s_o    = sda_ff[STAGES-1];
  assign scl_rise_o = scl_s_o & ~scl_q;
  assign scl_fall_o = ~scl_s_o & scl_q;
  assign start_o    = scl_s_o & scl_q & sda_q & ~sda_s_o;
  assign stop_o     = scl_s_o & scl_q & ~sda_q & sda_s_o;
endmodule

// File: rtl/i2c_ctl_link.sv
module i2c_ctl_link
  import i2c_ctl_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h42
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        sda_s_i,
  input  logic        scl_rise_i,
  input  logic        scl_fall_i,
  input  logic        start_i,
  input  logic        stop_i,
  input  logic [7:0]  status_i,
  output logic        sda_oe_o,
  output logic        byte_vld_o,
  output logic [7:0]  byte_o,
  output bit_st_e     state_o,
  output logic [7:0]  status_cap_o
);
  bit_st_e    state_q;
  logic [3:0] cnt_q;
  logic [7:0] shr_q, tx_q, cap_q, byte_q;
  logic       oe_q, vld_q, rw_q, mack_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      shr_q   <= '0;
      tx_q    <= '0;
      cap_q   <= '0;
      byte_q  <= '0;
      oe_q    <= 1'b0;
      vld_q   <= 1'b0;
      rw_q    <= 1'b0;
      mack_q  <= 1'b0;
    end else begin
      vld_q <= 1'b0;
      if (start_i) begin
        state_q <= ST_ADDR;
        cnt_q   <= '0;
        oe_q    <= 1'b0;
      end else if (stop_i) begin
        state_q <= ST_IDLE;
        oe_q    <= 1'b0;
      end else begin
        unique case (state_q)
          ST_ADDR, ST_WDATA: begin
            if (scl_rise_i && cnt_q != 4'd8) begin
              shr_q <= {shr_q[6:0], sda_s_i};
              cnt_q <= cnt_q + 4'd1;
            end else if (scl_fall_i && cnt_q == 4'd8) begin
              cnt_q <= '0;
              if (state_q == ST_ADDR) begin
                if (shr_q[7:1] == DEV_ADDR) begin
                  oe_q    <= 1'b1;
                  state_q <= ST_AACK;
                  rw_q    <= shr_q[0];
                  if (shr_q[0]) cap_q <= status_i;  // freeze status for the read
                end else begin
                  state_q <= ST_IDLE;
                end
              end else begin
                vld_q   <= 1'b1;
                byte_q  <= shr_q;
                oe_q    <= 1'b1;
                state_q <= ST_WACK;
              end
            end
          end
          ST_AACK: if (scl_fall_i) begin
            if (rw_q) begin
              state_q <= ST_RDATA;
              tx_q    <= cap_q;
              oe_q    <= ~cap_q[7];
              cnt_q   <= '0;
            end else begin
              oe_q    <= 1'b0;
              state_q <= ST_WDATA;
            end
          end
          ST_WACK: if (scl_fall_i) begin
            oe_q    <= 1'b0;
            state_q <= ST_WDATA;
          end
          ST_RDATA: if (scl_fall_i) begin
            if (cnt_q == 4'd7) begin
              oe_q    <= 1'b0;
              state_q <= ST_RACK;
            end else begin
              tx_q  <= {tx_q[6:0], 1'b0};
              oe_q  <= ~tx_q[6];
              cnt_q <= cnt_q + 4'd1;
            end
          end
          ST_RACK: begin
            if (scl_rise_i) mack_q <= ~sda_s_i;
            else if (scl_fall_i) begin
              if (mack_q) begin
                state_q <= ST_RDATA;
                tx_q    <= cap_q;
                oe_q    <= ~cap_q[7];
                cnt_q   <= '0;
              end else begin
                state_q <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end

  assign sda_oe_o     = oe_q;
  assign byte_vld_o   = vld_q;
  assign byte_o       = byte_q;
  assign state_o      = state_q;
  assign status_cap_o = cap_q;
endmodule

// File: rtl/i2c_ctl_regs.sv
module i2c_ctl_regs #(
  parameter int NUM_REGS = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  rearm_i,
  input  logic                  byte_vld_i,
  input  logic [7:0]            byte_i,
  output logic [NUM_REGS*8-1:0] regs_o,
  output logic                  wr_stb_o,
  output logic [7:0]            wr_sub_o
);
  localparam logic [8:0] NREG_L = 9'(NUM_REGS);

  logic       want_sub_q, stb_q;
  logic [7:0] sub_q, wsub_q;
  logic       wr_en;

  assign wr_en = byte_vld_i & ~want_sub_q & ~rearm_i & ({1'b0, sub_q} < NREG_L);

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      want_sub_q <= 1'b1;
      sub_q      <= '0;
      stb_q      <= 1'b0;
      wsub_q     <= '0;
    end else begin
      stb_q <= wr_en;
      if (wr_en) wsub_q <= sub_q;
      if (rearm_i) want_sub_q <= 1'b1;
      else if (byte_vld_i) begin
        if (want_sub_q) sub_q <= byte_i;
        want_sub_q <= ~want_sub_q;
      end
    end

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni)
      if (!rst_ni) regs_o[i*8 +: 8] <= '0;
      else if (wr_en && sub_q == 8'(i)) regs_o[i*8 +: 8] <= byte_i;
  end

  assign wr_stb_o = stb_q;
  assign wr_sub_o = wsub_q;
endmodule

// File: rtl/i2c_ctl_slave.sv
module i2c_ctl_slave
  import i2c_ctl_pkg::*;
#(
  parameter int         NUM_REGS    = 8,
  parameter int         SYNC_STAGES = 2,
  parameter logic [6:0] DEV_ADDR    = 7'h42
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  scl_i,
  input  logic                  sda_i,
  output logic                  sda_oe_o,
  input  logic [7:0]            status_i,
  output logic [NUM_REGS*8-1:0] regs_o,
  output logic                  wr_stb_o,
  output logic [7:0]            wr_sub_o
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_p, stop_p;
  logic byte_vld;
  logic [7:0] byte_d, status_cap;
  bit_st_e link_state;

  i2c_ctl_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_s_o(scl_s), .sda_s_o(sda_s), .scl_rise_o(scl_rise),
    .scl_fall_o(scl_fall), .start_o(start_p), .stop_o(stop_p)
  );

  i2c_ctl_link #(.DEV_ADDR(DEV_ADDR)) u_link (
    .clk_i, .rst_ni, .sda_s_i(sda_s), .scl_rise_i(scl_rise),
    .scl_fall_i(scl_fall), .start_i(start_p), .stop_i(stop_p),
    .status_i, .sda_oe_o, .byte_vld_o(byte_vld), .byte_o(byte_d),
    .state_o(link_state), .status_cap_o(status_cap)
  );

  i2c_ctl_regs #(.NUM_REGS(NUM_REGS)) u_regs (
    .clk_i, .rst_ni, .rearm_i(start_p | stop_p), .byte_vld_i(byte_vld),
    .byte_i(byte_d), .regs_o, .wr_stb_o, .wr_sub_o
  );
endmodule

// File: rtl/i2c_ctl_chk.sv
module i2c_ctl_chk
  import i2c_ctl_pkg::*;
#(
  parameter int NUM_REGS = 8
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  scl_s,
  input logic                  sda_oe_o,
  input logic [NUM_REGS*8-1:0] regs_o,
  input logic                  wr_stb_o,
  input logic [7:0]            wr_sub_o,
  input bit_st_e               state_i,
  input logic [7:0]            status_cap
);
  AST_OE_SCL_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni) $past(scl_s) |-> $stable(sda_oe_o)); // R8
  AST_IDLE_RELEASED: assert property (@(posedge clk_i) disable iff (!rst_ni) (state_i == ST_IDLE) |-> !sda_oe_o); // R8
  AST_REG_NEEDS_STB: assert property (@(posedge clk_i) disable iff (!rst_ni) !$stable(regs_o) |-> wr_stb_o); // R3
  AST_STB_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni) wr_stb_o |=> !wr_stb_o); // R3
  AST_SUB_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni) wr_stb_o |-> ({1'b0, wr_sub_o} < 9'(NUM_REGS))); // R4
  AST_TX_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni) (state_i == ST_RDATA && $past(state_i) == ST_RDATA) |-> $stable(status_cap)); // R7
endmodule

bind i2c_ctl_slave i2c_ctl_chk #(.NUM_REGS(NUM_REGS)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .scl_s(scl_s), .sda_oe_o(sda_oe_o),
  .regs_o(regs_o), .wr_stb_o(wr_stb_o), .wr_sub_o(wr_sub_o),
  .state_i(link_state), .status_cap(status_cap)
);

// File: tb/i2c_ctl_slave_tb_top.sv
module i2c_ctl_slave_tb_top;
  localparam int NREG = 8;
  localparam int H    = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe, wr_stb;
  logic [7:0] status = 8'h00, wr_sub;
  logic [NREG*8-1:0] regs;
  wire sda_line = sda_m & ~sda_oe;

  always #2 clk = ~clk;

  i2c_ctl_slave dut_i (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .status_i(status), .regs_o(regs),
    .wr_stb_o(wr_stb), .wr_sub_o(wr_sub)
  );

  int checks = 0, fails = 0;
  logic [7:0] exp_regs [NREG];
  bit exp_want_sub = 1'b1;
  int exp_sub = 0, exp_stb = 0, stb_seen = 0;
  bit cmp_en = 1'b0;

  function automatic logic [NREG*8-1:0] exp_vec();
    logic [NREG*8-1:0] v;
    for (int k = 0; k < NREG; k++) v[k*8 +: 8] = exp_regs[k];
    return v;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // reference model, checked on every clock
  always @(negedge clk) begin
    if (rst_n && wr_stb) stb_seen++;
    if (rst_n && cmp_en) chk(regs == exp_vec(), "R3 register bank", regs, exp_vec());
  end

  function automatic void model_byte(input logic [7:0] b);
    if (exp_want_sub) begin
      exp_sub = b;
      exp_want_sub = 1'b0;
    end else begin
      exp_want_sub = 1'b1;
      if (exp_sub < NREG) begin
        exp_regs[exp_sub] = b;
        exp_stb++;
      end
    end
  endfunction

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    sda_m = b; wclk(H); scl_m = 1'b1; wclk(H); scl_m = 1'b0; wclk(1);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wclk(H); scl_m = 1'b1; wclk(H); sda_m = 1'b0; wclk(H);
    scl_m = 1'b0; wclk(1);
    exp_want_sub = 1'b1;
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wclk(H); scl_m = 1'b1; wclk(H); sda_m = 1'b1; wclk(H);
    exp_want_sub = 1'b1;
  endtask

  task automatic wr_byte(input logic [7:0] b, input bit exp_ack, input bit to_model, input string req);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    sda_m = 1'b1;
    cmp_en = 1'b0;
    wclk(H);
    if (to_model) model_byte(b);
    cmp_en = 1'b1;
    scl_m = 1'b1; wclk(H/2);
    chk(sda_oe == exp_ack, req, 64'(sda_oe), 64'(exp_ack));
    wclk(H/2); scl_m = 1'b0; wclk(1);
  endtask

  task automatic rd_byte(input bit mack, output logic [7:0] d);
    sda_m = 1'b1;
    d = '0;
    for (int i = 0; i < 8; i++) begin
      wclk(H); scl_m = 1'b1; wclk(H/2);
      d = {d[6:0], sda_line};
      wclk(H/2); scl_m = 1'b0; wclk(1);
    end
    send_bit(~mack);
    sda_m = 1'b1;
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    report();
    $finish;
  end

  initial begin
    logic [7:0] rd;
    for (int k = 0; k < NREG; k++) exp_regs[k] = 8'h00;
    wclk(4); rst_n = 1'b1; wclk(4);

    // R1 reset state
    chk(regs == '0, "R1 regs after reset", regs, 0);
    chk(!sda_oe, "R1 sda released", 64'(sda_oe), 0);
    chk(!wr_stb, "R1 no strobe", 64'(wr_stb), 0);
    cmp_en = 1'b1;

    // R2/R3 correct volume stepping, one pair per step
    bus_start();
    wr_byte(8'h84, 1, 0, "R2 write address ack");
    wr_byte(8'h03, 1, 1, "R2 sub ack");
    wr_byte(8'h08, 1, 1, "R2 data ack");
    chk(regs[31:24] == 8'h08, "R3 reg3 step 8", regs[31:24], 8'h08);
    wr_byte(8'h03, 1, 1, "R2 sub ack");
    wr_byte(8'h09, 1, 1, "R2 data ack");
    wr_byte(8'h03, 1, 1, "R2 sub ack");
    wr_byte(8'h0A, 1, 1, "R2 data ack");
    bus_stop();
    chk(!sda_oe, "R8 released after stop", 64'(sda_oe), 0);
    chk(regs[31:24] == 8'h0A, "R3 reg3 step 10", regs[31:24], 8'h0A);
    chk(stb_seen == exp_stb, "R3 strobe count", stb_seen, exp_stb);

    // R4 unpaired data: 09 becomes an out-of-range sub-address
    bus_start();
    wr_byte(8'h84, 1, 0, "R2 write address ack");
    wr_byte(8'h03, 1, 1, "R4 sub ack");
    wr_byte(8'h05, 1, 1, "R4 data ack");
    wr_byte(8'h09, 1, 1, "R4 stray ack");
    wr_byte(8'h0A, 1, 1, "R4 stray ack");
    bus_stop();
    chk(regs[31:24] == 8'h05, "R4 reg3 keeps paired value", regs[31:24], 8'h05);
    chk(stb_seen == exp_stb, "R4 no strobe for stray", stb_seen, exp_stb);

    // R6 mixed sub-addresses in one transaction
    bus_start();
    wr_byte(8'h84, 1, 0, "R2 write address ack");
    wr_byte(8'h01, 1, 1, "R6 ack"); wr_byte(8'h55, 1, 1, "R6 ack");
    wr_byte(8'h07, 1, 1, "R6 ack"); wr_byte(8'hAA, 1, 1, "R6 ack");
    wr_byte(8'h00, 1, 1, "R6 ack"); wr_byte(8'h3C, 1, 1, "R6 ack");
    bus_stop();
    chk(regs[15:8] == 8'h55 && regs[63:56] == 8'hAA && regs[7:0] == 8'h3C,
        "R6 mixed pairs", regs, exp_vec());

    // R2 foreign address not acknowledged, bytes ignored
    bus_start();
    wr_byte(8'h90, 0, 0, "R2 foreign address nack");
    wr_byte(8'h02, 0, 0, "R2 ignored byte nack");
    wr_byte(8'h77, 0, 0, "R2 ignored byte nack");
    bus_stop();
    chk(regs[23:16] == 8'h00, "R2 foreign write ignored", regs[23:16], 0);

    // R5 repeated start re-arms the pairing
    bus_start();
    wr_byte(8'h84, 1, 0, "R2 write address ack");
    wr_byte(8'h02, 1, 1, "R5 dangling sub ack");
    bus_start();
    wr_byte(8'h84, 1, 0, "R2 write address ack");
    wr_byte(8'h06, 1, 1, "R5 ack");
    wr_byte(8'h11, 1, 1, "R5 ack");
    bus_stop();
    chk(regs[55:48] == 8'h11, "R5 reg6 after rearm", regs[55:48], 8'h11);
    chk(regs[23:16] == 8'h00, "R5 reg2 untouched", regs[23:16], 0);

    // R5 stop also re-arms
    bus_start();
    wr_byte(8'h84, 1, 0, "R2 write address ack");
    wr_byte(8'h04, 1, 1, "R5 ack");
    bus_stop();
    bus_start();
    wr_byte(8'h84, 1, 0, "R2 write address ack");
    wr_byte(8'h05, 1, 1, "R5 ack");
    wr_byte(8'h66, 1, 1, "R5 ack");
    bus_stop();
    chk(regs[47:40] == 8'h66 && regs[39:32] == 8'h00, "R5 stop rearm", regs[47:32], 16'h6600);

    // R7 read: captured status, MSB first, repeated on master ACK
    status = 8'hA5;
    bus_start();
    wr_byte(8'h85, 1, 0, "R2 read address ack");
    status = 8'h3C;
    rd_byte(1'b1, rd);
    chk(rd == 8'hA5, "R7 first status byte", rd, 8'hA5);
    rd_byte(1'b0, rd);
    chk(rd == 8'hA5, "R7 repeated captured byte", rd, 8'hA5);
    chk(!sda_oe, "R7 released after nack", 64'(sda_oe), 0);
    bus_stop();

    // R7 fresh read picks up the new status
    bus_start();
    wr_byte(8'h85, 1, 0, "R2 read address ack");
    rd_byte(1'b0, rd);
    chk(rd == 8'h3C, "R7 new status captured", rd, 8'h3C);
    bus_stop();
    chk(!sda_oe, "R8 idle released", 64'(sda_oe), 0);
    chk(stb_seen == exp_stb, "R3 final strobe count", stb_seen, exp_stb);

    wclk(4);
    report();
    $finish;
  end
endmodule